// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block brings an LCD panel interface up and down in a safe order. Software issues single-cycle enable and disable requests. The block drives two outputs. The first is a controller-enable line that wakes the timing and pixel path. The second is a panel-power line. A millisecond prescaler, derived from the system clock, times a fixed settle interval between the two steps.

Power-up raises controller enable first and applies panel power only after the settle interval. Power-down removes panel power first, waits the settle interval, then drops controller enable. A step whose output already has its target value is skipped, and so is the wait that would follow it. A busy flag is high for as long as a settle wait runs. A disable request can abort a power-up that is still waiting. Blanking the display maps to a disable request, and unblanking maps to an enable request.

Top module: `lcd_pwr_seq`

## Requirements
- R1: After reset, `ctrl_en_o`, `panel_pwr_o` and `busy_o` are all low.
- R2: An enable request with both outputs low raises `ctrl_en_o` on the clock edge that accepts it, while `panel_pwr_o` stays low. `panel_pwr_o` is never high while `ctrl_en_o` is low.
- R3: `panel_pwr_o` rises exactly SETTLE_MS*CYC_PER_MS clock cycles after `ctrl_en_o` rose.
- R4: A disable request with both outputs high lowers `panel_pwr_o` on the accepting edge. `ctrl_en_o` falls exactly SETTLE_MS*CYC_PER_MS cycles later.
- R5: A disable request while panel power is off and controller enable is on (during the power-up wait) clears `ctrl_en_o` on the accepting edge. No wait follows, and `busy_o` drops on that same edge.
- R6: A disable request with both outputs low changes nothing and starts no wait.
- R7: An enable request with both outputs already high changes nothing and starts no wait.
- R8: `busy_o` is high from the edge that starts a settle wait until the edge that ends or aborts it, and low at all other times.
- R9: Enable and disable requests that arrive during the power-down wait are ignored.
- R10: A disable request wins over an enable request in the same cycle. It also wins over the expiry of the power-up wait in the same cycle. In that case `ctrl_en_o` is cleared and `panel_pwr_o` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_req_i | input | 1 | Single-cycle power-up (unblank) request |
| dis_req_i | input | 1 | Single-cycle power-down (blank) request |
| ctrl_en_o | output | 1 | Controller enable for the timing and data path |
| panel_pwr_o | output | 1 | Panel power enable |
| busy_o | output | 1 | High while a settle wait is running |

## Verification
Two pairs of events can land in the same cycle: a disable request and an enable request, and a disable request and the expiry of the power-up wait. The first pair is provoked by pulsing both requests together while the panel is off. It is judged correct when neither output moves and busy stays low. The second pair is provoked by timing the disable pulse so that it is accepted on exactly the edge where panel power would otherwise rise. It is judged correct when controller enable falls on that edge and panel power never rises over the following hundred cycles.

// File: rtl/lcd_pwr_pkg.sv
package lcd_pwr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_UP_WAIT = 2'd1,
    ST_DN_WAIT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ms_tick_gen.sv
module ms_tick_gen #(
  parameter int unsigned CYC_PER_MS = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(CYC_PER_MS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= RELOAD;
    end else if (run_i) begin
      cnt_q <= (cnt_q == '0) ? RELOAD : cnt_q - 1'b1;
    end
  end

  assign tick_o = run_i && !restart_i && (cnt_q == '0);

  a_r3_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= RELOAD);
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int unsigned SETTLE_MS = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic clear_i,
  input  logic tick_i,
  output logic run_o,
  output logic done_o
);
  localparam int unsigned MW = $clog2(SETTLE_MS + 1);
  localparam logic [MW-1:0] MS_LOAD = MW'(SETTLE_MS);
  localparam logic [MW-1:0] MS_ONE  = MW'(1);

  logic [MW-1:0] ms_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ms_q  <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      ms_q  <= MS_LOAD;
      run_q <= 1'b1;
    end else if (clear_i) begin
      run_q <= 1'b0;
    end else if (run_q && tick_i) begin
      if (ms_q == MS_ONE) run_q <= 1'b0;
      else                ms_q  <= ms_q - 1'b1;
    end
  end

  assign run_o  = run_q;
  assign done_o = run_q && tick_i && (ms_q == MS_ONE);

  a_r3_ms_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (ms_q != '0 && ms_q <= MS_LOAD));
  a_r8_done_ends_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !run_q);
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import lcd_pwr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_req_i,
  input  logic dis_req_i,
  input  logic done_i,
  input  logic run_i,
  output logic start_o,
  output logic clear_o,
  output logic ctrl_en_o,
  output logic panel_pwr_o
);
  seq_state_e state_q, state_d;
  logic ctrl_q, ctrl_d, pwr_q, pwr_d;

  always_comb begin
    state_d = state_q;
    ctrl_d  = ctrl_q;
    pwr_d   = pwr_q;
    start_o = 1'b0;
    clear_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (dis_req_i) begin
          if (pwr_q) begin
            pwr_d   = 1'b0;
            start_o = 1'b1;
            state_d = ST_DN_WAIT;
          end else begin
            ctrl_d = 1'b0;   // no wait when the panel is already unpowered
          end
        end else if (en_req_i && !pwr_q) begin
          ctrl_d  = 1'b1;
          start_o = 1'b1;
          state_d = ST_UP_WAIT;
        end
      end
      ST_UP_WAIT: begin
        if (dis_req_i) begin
          ctrl_d  = 1'b0;    // abort: panel never powered
          clear_o = 1'b1;
          state_d = ST_IDLE;
        end else if (done_i) begin
          pwr_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_DN_WAIT: begin
        if (done_i) begin
          ctrl_d  = 1'b0;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ctrl_q  <= 1'b0;
      pwr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ctrl_q  <= ctrl_d;
      pwr_q   <= pwr_d;
    end
  end

  assign ctrl_en_o   = ctrl_q;
  assign panel_pwr_o = pwr_q;

  a_r2_pwr_needs_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_q |-> ctrl_q);
  a_r2_up_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_q) |-> $past(ctrl_q));
  a_r4_dn_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_q) |-> !$past(pwr_q));
  a_r8_busy_tracks_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) == run_i);
  a_r6_off_stays_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !ctrl_q && dis_req_i) |=> (!ctrl_q && !pwr_q && !run_i));
  a_r9_dn_wait_no_power: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DN_WAIT) |=> !pwr_q);
endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq #(
  parameter int unsigned CYC_PER_MS = 50000,
  parameter int unsigned SETTLE_MS  = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_req_i,
  input  logic dis_req_i,
  output logic ctrl_en_o,
  output logic panel_pwr_o,
  output logic busy_o
);
  logic start, clear, tick, run, done;

  ms_tick_gen #(.CYC_PER_MS(CYC_PER_MS)) u_tick (
    .clk_i, .rst_ni,
    .restart_i (start),
    .run_i     (run),
    .tick_o    (tick)
  );

  settle_timer #(.SETTLE_MS(SETTLE_MS)) u_timer (
    .clk_i, .rst_ni,
    .start_i (start),
    .clear_i (clear),
    .tick_i  (tick),
    .run_o   (run),
    .done_o  (done)
  );

  pwr_seq_fsm u_fsm (
    .clk_i, .rst_ni,
    .en_req_i, .dis_req_i,
    .done_i      (done),
    .run_i       (run),
    .start_o     (start),
    .clear_o     (clear),
    .ctrl_en_o   (ctrl_en_o),
    .panel_pwr_o (panel_pwr_o)
  );

  assign busy_o = run;

  a_r10_no_power_on_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_req_i |=> !$rose(panel_pwr_o));
endmodule

// File: tb/lcd_pwr_seq_test.sv
`timescale 1ns/1ps
module lcd_pwr_seq_test;
  localparam int unsigned CPM = 4;
  localparam int unsigned SMS = 20;
  localparam int unsigned WAIT = CPM * SMS;

  typedef struct {
    int unsigned at;
    logic        c;
    logic        p;
    string       tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, dis = 1'b0;
  logic ctrl, pwr, busy;
  int unsigned cyc = 0, acc = 0;
  int tests = 0, fails = 0;
  bit finished = 1'b0;
  logic [1:0] last = 2'b00;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lcd_pwr_seq #(.CYC_PER_MS(CPM), .SETTLE_MS(SMS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_req_i(en), .dis_req_i(dis),
    .ctrl_en_o(ctrl), .panel_pwr_o(pwr), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push(input int unsigned at, input logic c, input logic p, input string tag);
    exp_t e;
    e.at = at; e.c = c; e.p = p; e.tag = tag;
    q.push_back(e);
  endtask

  // drive request on a falling edge; acc is the edge that accepts it
  task automatic arm(input logic e, input logic d);
    @(negedge clk);
    en = e; dis = d;
    acc = cyc + 1;
  endtask

  task automatic release_req();
    @(negedge clk);
    en = 1'b0; dis = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every output change must match the next scoreboard entry
  always @(posedge clk) begin
    #2;
    if (rst_n && {ctrl, pwr} != last) begin
      if (q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R6 R7 R9: unexpected change to ctrl=%0d pwr=%0d expected no change (cycle %0d)",
                 ctrl, pwr, cyc);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(e.at == cyc, e.tag, cyc, e.at);
        chk(ctrl == e.c && pwr == e.p, e.tag, {ctrl, pwr}, {e.c, e.p});
      end
      last = {ctrl, pwr};
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    chk(!ctrl && !pwr && !busy, "R1", {ctrl, pwr, busy}, 0);
    rst_n = 1'b1;
    wait_cyc(2);
    chk(!ctrl && !pwr && !busy, "R1", {ctrl, pwr, busy}, 0);

    // R2/R3 power-up
    arm(1, 0);
    push(acc, 1, 0, "R2");
    push(acc + WAIT, 1, 1, "R3");
    release_req();
    chk(busy, "R8", busy, 1);
    wait_cyc(40);
    chk(busy && !pwr, "R2", {busy, pwr}, 2);
    wait_cyc(45);
    chk(!busy && pwr && ctrl, "R8", {busy, pwr, ctrl}, 3);

    // R7 enable while on
    arm(1, 0);
    release_req();
    wait_cyc(5);
    chk(!busy && ctrl && pwr, "R7", {busy, ctrl, pwr}, 3);

    // R4 power-down, R9 requests during the wait ignored
    arm(0, 1);
    push(acc, 1, 0, "R4");
    push(acc + WAIT, 0, 0, "R4");
    release_req();
    wait_cyc(30);
    chk(busy, "R8", busy, 1);
    arm(1, 0);
    release_req();
    arm(0, 1);
    release_req();
    chk(busy && ctrl && !pwr, "R9", {busy, ctrl, pwr}, 6);
    wait_cyc(60);
    chk(!busy && !ctrl && !pwr, "R9", {busy, ctrl, pwr}, 0);

    // R6 disable while off
    arm(0, 1);
    release_req();
    wait_cyc(3);
    chk(!busy && !ctrl && !pwr, "R6", {busy, ctrl, pwr}, 0);

    // R10 both requests together
    arm(1, 1);
    release_req();
    wait_cyc(3);
    chk(!busy && !ctrl && !pwr, "R10", {busy, ctrl, pwr}, 0);

    // R5 abort during power-up wait
    arm(1, 0);
    push(acc, 1, 0, "R2");
    release_req();
    wait_cyc(28);
    arm(0, 1);
    push(acc, 0, 0, "R5");
    release_req();
    chk(!busy && !ctrl, "R5", {busy, ctrl}, 0);
    wait_cyc(100);
    chk(!pwr && !busy, "R5", {pwr, busy}, 0);

    // R10 disable on the expiry edge
    arm(1, 0);
    push(acc, 1, 0, "R2");
    release_req();
    wait_cyc(78);
    arm(0, 1);
    chk(acc == cyc + 1, "R10", acc, cyc + 1);
    push(acc, 0, 0, "R10");
    release_req();
    wait_cyc(100);
    chk(!pwr && !ctrl && !busy, "R10", {pwr, ctrl, busy}, 0);

    chk(q.size() == 0, "R3 pending", q.size(), 0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule